// File: doc/BRIEF.md
# Two-Engine UART DMA Controller

This block holds two DMA engines that share one memory bus master port. Each engine can serve its own UART data port in fly-by fashion. In that case a single bus cycle carries the data straight between the UART and a memory address. Receive data goes from the UART into memory, and transmit data goes from memory out to the UART.

The two engines can also be tied together as a memory-to-memory pair. Engine 0 reads from its source address into a single-entry holding register. Engine 1 writes that value to its destination address. A full flag lets the two engines take turns, so that no unit is lost or copied twice.

Each engine is set up through one configuration write port. A write gives a memory address, a unit count, a unit width (byte, half-word or word), a direction, demand or burst operation, and the pair role. The memory address advances by the unit width after every unit. The UART side has no address. Each engine signals completion with a one-cycle done pulse.

Top module: `uart_dma_pair`

## Requirements
- R1: While reset is applied and after it is released, no bus request, UART acknowledge or done pulse is issued until an engine has been configured.
- R2: `cfg_width` codes 0, 1 and 2 select byte, half-word and word. Code 3 is treated as word. `mem_size` shows the code 0, 1 or 2, and the memory address steps by 1, 2 or 4 after each unit, starting at `cfg_addr`.
- R3: An engine moves exactly `cfg_count` units. It raises its `done_irq` bit for one cycle, in the cycle after the last unit's bus transfer. A write with a count of 0 starts nothing.
- R4: In demand fly-by mode, each `uart_req` of the engine's port moves one unit. The matching `uart_ack` bit is high in the same cycle as that unit's granted bus transfer. With the request low, no bus request is made.
- R5: In burst fly-by mode, one request starts the transfer. After that a unit moves in every granted cycle until the count is used up, whatever the request line does.
- R6: With `cfg_to_uart` = 0 the unit is a bus write (`mem_we` = 1) carrying the port's receive data. With `cfg_to_uart` = 1 it is a bus read (`mem_we` = 0), and `uart_tx_data` carries `mem_rdata`.
- R7: With `cfg_pair` set on both engines, engine 0 reads and engine 1 writes, strictly taking turns. Each write carries the data of the read before it. Paired engines neither use `uart_req` nor raise `uart_ack`.
- R8: A configuration write to an engine that is not idle has no effect on that engine, either now or after it finishes.
- R9: When both engines request, engine 0 wins, unless engine 1 has a burst under way. Once a burst has moved its first unit, it keeps the bus until its count is used up.
- R10: While `mem_gnt` is low, a pending bus request stays asserted with the same address and direction.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Engine addressed by the write |
| cfg_addr | input | AW | Start memory address |
| cfg_count | input | CW | Number of units |
| cfg_width | input | 2 | Unit width code |
| cfg_to_uart | input | 1 | 1: memory to UART, 0: UART to memory |
| cfg_burst | input | 1 | 1: burst, 0: demand |
| cfg_pair | input | 1 | Engine takes its role in the memory-to-memory pair |
| uart_req | input | 2 | Per-port transfer request |
| uart_ack | output | 2 | Per-port unit acknowledge |
| uart_rx_data0 | input | DW | Receive data of port 0 |
| uart_rx_data1 | input | DW | Receive data of port 1 |
| uart_tx_data | output | DW | Transmit data toward the acknowledged port |
| mem_req | output | 1 | Bus request |
| mem_gnt | input | 1 | Bus grant; a unit moves when request and grant are both high |
| mem_we | output | 1 | Bus write |
| mem_addr | output | AW | Bus byte address |
| mem_size | output | 2 | Bus unit size code |
| mem_wdata | output | DW | Bus write data |
| mem_rdata | input | DW | Bus read data, valid in the granted cycle |
| done_irq | output | 2 | Per-engine completion pulse |

## Verification
The assertions assume that the bus returns read data in the same cycle as the grant. They also assume that a UART in demand mode drops its request in the cycle after it sees its acknowledge, and that pairing is set on both engines together. The stimulus follows all three. It drives `mem_gnt`, the requests and the configuration only at falling edges. It lowers a demand request as soon as the acknowledge appears, and it always sets up the writer engine of a pair before the reader. Stalls are made by pulling `mem_gnt` low in the middle of a burst, so the checks on held requests see real wait cycles.

// File: rtl/udma_pkg.sv
package udma_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } unit_size_e;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_WAIT = 2'd1,
    ENG_RUN  = 2'd2
  } eng_state_e;

  function automatic unit_size_e size_from_code(input logic [1:0] code);
    case (code)
      2'd0:    return SZ_BYTE;
      2'd1:    return SZ_HALF;
      default: return SZ_WORD;
    endcase
  endfunction

  function automatic logic [2:0] size_step(input unit_size_e sz);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/udma_engine.sv
module udma_engine
  import udma_pkg::*;
#(
  parameter int AW        = 16,
  parameter int CW        = 8,
  parameter bit IS_WRITER = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_count,
  input  logic [1:0]    cfg_width,
  input  logic          cfg_to_uart,
  input  logic          cfg_burst,
  input  logic          cfg_pair,
  input  logic          uart_req,
  input  logic          hold_full,
  input  logic          xfer,
  output logic          want,
  output logic          hold_bus,
  output logic [AW-1:0] addr,
  output unit_size_e    size,
  output logic          wr,
  output logic          paired,
  output logic          done
);

  eng_state_e    st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          started_q, started_d;
  logic          done_q, done_d;
  logic          load;

  unit_size_e    size_q;
  logic          to_uart_q, burst_q, pair_q;

  logic          trig;

  // Paired role waits on the holding flag; fly-by waits on the UART.
  assign trig = pair_q ? (IS_WRITER ? hold_full : !hold_full) : uart_req;

  always_comb begin
    st_d      = st_q;
    addr_d    = addr_q;
    cnt_d     = cnt_q;
    started_d = started_q;
    done_d    = 1'b0;
    load      = 1'b0;
    case (st_q)
      ENG_IDLE: begin
        if (cfg_we && (cfg_count != '0)) begin
          load   = 1'b1;
          addr_d = cfg_addr;
          cnt_d  = cfg_count;
          st_d   = ENG_WAIT;
        end
      end
      ENG_WAIT: begin
        if (trig) st_d = ENG_RUN;
      end
      ENG_RUN: begin
        if (xfer) begin
          addr_d    = addr_q + AW'(size_step(size_q));
          cnt_d     = cnt_q - 1'b1;
          started_d = 1'b1;
          if (cnt_q == CW'(1)) begin
            st_d      = ENG_IDLE;
            done_d    = 1'b1;
            started_d = 1'b0;
          end else if (burst_q && !pair_q) begin
            st_d = ENG_RUN;
          end else begin
            st_d      = ENG_WAIT;
            started_d = 1'b0;
          end
        end
      end
      default: st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ENG_IDLE;
      addr_q    <= '0;
      cnt_q     <= '0;
      started_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      addr_q    <= addr_d;
      cnt_q     <= cnt_d;
      started_q <= started_d;
      done_q    <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q    <= SZ_BYTE;
      to_uart_q <= 1'b0;
      burst_q   <= 1'b0;
      pair_q    <= 1'b0;
    end else if (load) begin
      size_q    <= size_from_code(cfg_width);
      to_uart_q <= cfg_to_uart;
      burst_q   <= cfg_burst;
      pair_q    <= cfg_pair;
    end
  end

  assign want     = (st_q == ENG_RUN);
  assign hold_bus = started_q;
  assign addr     = addr_q;
  assign size     = size_q;
  assign wr       = pair_q ? IS_WRITER : !to_uart_q;
  assign paired   = pair_q;
  assign done     = done_q;

endmodule

// File: rtl/udma_arb.sv
module udma_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] want,
  input  logic [1:0] hold_bus,
  input  logic       gnt,
  output logic       sel,
  output logic       req
);

  logic pend_q, pend_d;
  logic pend_sel_q, pend_sel_d;

  always_comb begin
    if (pend_q)           sel = pend_sel_q;
    else if (hold_bus[0]) sel = 1'b0;
    else if (hold_bus[1]) sel = 1'b1;
    else if (want[0])     sel = 1'b0;
    else                  sel = 1'b1;
    req        = want[sel];
    pend_d     = req && !gnt;
    pend_sel_d = sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_sel_q <= 1'b0;
    end else begin
      pend_q     <= pend_d;
      pend_sel_q <= pend_sel_d;
    end
  end

endmodule

// File: rtl/udma_hold.sv
module udma_hold #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill,
  input  logic          drain,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          full
);

  logic [DW-1:0] data_q;
  logic          full_q, full_d;

  always_comb begin
    full_d = full_q;
    if (fill)       full_d = 1'b1;
    else if (drain) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (fill) data_q <= din;
  end

  assign dout = data_q;
  assign full = full_q;

endmodule

// File: rtl/uart_dma_pair.sv
module uart_dma_pair
  import udma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_count,
  input  logic [1:0]    cfg_width,
  input  logic          cfg_to_uart,
  input  logic          cfg_burst,
  input  logic          cfg_pair,
  input  logic [1:0]    uart_req,
  output logic [1:0]    uart_ack,
  input  logic [DW-1:0] uart_rx_data0,
  input  logic [DW-1:0] uart_rx_data1,
  output logic [DW-1:0] uart_tx_data,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [1:0]    done_irq
);

  localparam int NENG = 2;

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [NENG-1:0] eng_want, eng_hold, eng_wr, eng_pair, eng_done, eng_xfer;
  logic [AW-1:0]   eng_addr [NENG];
  unit_size_e      eng_size [NENG];
  logic            arb_sel;
  logic            hold_full;
  logic [DW-1:0]   hold_dout;

  for (genvar i = 0; i < NENG; i++) begin : g_eng
    udma_engine #(
      .AW(AW), .CW(CW), .IS_WRITER(i == 1)
    ) u_eng (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .cfg_we     (cfg_we && (cfg_sel == 1'(i))),
      .cfg_addr   (cfg_addr),
      .cfg_count  (cfg_count),
      .cfg_width  (cfg_width),
      .cfg_to_uart(cfg_to_uart),
      .cfg_burst  (cfg_burst),
      .cfg_pair   (cfg_pair),
      .uart_req   (uart_req[i]),
      .hold_full  (hold_full),
      .xfer       (eng_xfer[i]),
      .want       (eng_want[i]),
      .hold_bus   (eng_hold[i]),
      .addr       (eng_addr[i]),
      .size       (eng_size[i]),
      .wr         (eng_wr[i]),
      .paired     (eng_pair[i]),
      .done       (eng_done[i])
    );
    assign eng_xfer[i] = mem_req && mem_gnt && (arb_sel == 1'(i));
    assign uart_ack[i] = eng_xfer[i] && !eng_pair[i];
  end

  udma_arb u_arb (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .want    (eng_want),
    .hold_bus(eng_hold),
    .gnt     (mem_gnt),
    .sel     (arb_sel),
    .req     (mem_req)
  );

  udma_hold #(.DW(DW)) u_hold (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .fill (eng_xfer[0] && eng_pair[0]),
    .drain(eng_xfer[1] && eng_pair[1]),
    .din  (mem_rdata),
    .dout (hold_dout),
    .full (hold_full)
  );

  assign mem_addr     = eng_addr[arb_sel];
  assign mem_size     = eng_size[arb_sel];
  assign mem_we       = eng_wr[arb_sel];
  assign mem_wdata    = eng_pair[arb_sel] ? hold_dout
                      : (arb_sel ? uart_rx_data1 : uart_rx_data0);
  assign uart_tx_data = mem_rdata;
  assign done_irq     = eng_done;

endmodule

// File: rtl/uart_dma_pair_chk.sv
module uart_dma_pair_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    mem_size,
  input logic [1:0]    uart_ack,
  input logic [1:0]    done_irq,
  input logic          hold_full
);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R4
  ack_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_ack != 2'b00) |-> mem_req && mem_gnt);

  // R3
  done0_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq[0] |=> !done_irq[0]);

  // R3
  done1_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq[1] |=> !done_irq[1]);

  // R2
  size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_size != 2'd3);

  // R7
  paired_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full && mem_req && mem_gnt && !mem_we |-> uart_ack != 2'b00);

endmodule

bind uart_dma_pair uart_dma_pair_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .mem_req  (mem_req),
  .mem_gnt  (mem_gnt),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_size (mem_size),
  .uart_ack (uart_ack),
  .done_irq (done_irq),
  .hold_full(hold_full)
);

// File: tb/sim_uart_dma_pair.sv
`timescale 1ns/1ps
module sim_uart_dma_pair;

  localparam int AW = 16;
  localparam int CW = 8;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic          cfg_we, cfg_sel, cfg_to_uart, cfg_burst, cfg_pair;
  logic [AW-1:0] cfg_addr;
  logic [CW-1:0] cfg_count;
  logic [1:0]    cfg_width;
  logic [1:0]    uart_req, uart_ack, done_irq, mem_size;
  logic [DW-1:0] rx0, rx1, uart_tx_data, mem_wdata, mem_rdata;
  logic          mem_req, mem_gnt, mem_we;
  logic [AW-1:0] mem_addr;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  uart_dma_pair #(.AW(AW), .CW(CW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_count(cfg_count), .cfg_width(cfg_width),
    .cfg_to_uart(cfg_to_uart), .cfg_burst(cfg_burst), .cfg_pair(cfg_pair),
    .uart_req(uart_req), .uart_ack(uart_ack), .uart_rx_data0(rx0),
    .uart_rx_data1(rx1), .uart_tx_data(uart_tx_data), .mem_req(mem_req),
    .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done_irq(done_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [DW-1:0] rd_val(input logic [AW-1:0] a);
    return {16'hC0DE, a};
  endfunction
  assign mem_rdata = rd_val(mem_addr);

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int e, input logic [AW-1:0] a, input int cnt,
                     input int w, input bit to_u, input bit bu, input bit pr);
    cfg_sel = 1'(e); cfg_addr = a; cfg_count = CW'(cnt);
    cfg_width = 2'(w); cfg_to_uart = to_u; cfg_burst = bu; cfg_pair = pr;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_ack(input int e, output bit got);
    got = 1'b0;
    for (int t = 0; t < 20; t++) begin
      if (uart_ack[e]) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic quiet(input int n, input string tag);
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      chk(!mem_req, tag, 32'(mem_req), 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: got %h expected %h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    bit got;
    int step;
    int seen, d0, d1;
    logic [AW-1:0] base, held;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_addr = '0;
    cfg_count = '0; cfg_width = '0; cfg_to_uart = 1'b0; cfg_burst = 1'b0;
    cfg_pair = 1'b0; uart_req = 2'b00; rx0 = '0; rx1 = '0; mem_gnt = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(!mem_req && uart_ack == 2'b00 && done_irq == 2'b00, "R1 reset quiet",
        {29'd0, mem_req, done_irq}, 32'd0);

    // R4 R2 R6 R3 demand fly-by sweep
    for (int e = 0; e < 2; e++)
      for (int w = 0; w < 3; w++)
        for (int d = 0; d < 2; d++) begin
          step = 1 << w;
          base = AW'(16'h1000 + e * 16'h100 + w * 16'h20 + d * 16'h8);
          cfg(e, base, 3, w, d[0], 1'b0, 1'b0);
          quiet(3, "R4 no request no bus");
          for (int k = 0; k < 3; k++) begin
            if (e == 0) rx0 = 32'h5A5A_0000 + 32'(k);
            else        rx1 = 32'h6B6B_0000 + 32'(k);
            uart_req[e] = 1'b1;
            wait_ack(e, got);
            chk(got, "R4 ack seen", 32'(got), 32'd1);
            chk(mem_addr == base + AW'(k * step), "R2 address",
                32'(mem_addr), 32'(base + AW'(k * step)));
            chk(mem_size == 2'(w), "R2 size", 32'(mem_size), 32'(w));
            chk(mem_we == !d[0], "R6 direction", 32'(mem_we), 32'(!d[0]));
            if (d == 0)
              chk(mem_wdata == (e == 0 ? rx0 : rx1), "R6 write data",
                  mem_wdata, (e == 0 ? rx0 : rx1));
            else
              chk(uart_tx_data == rd_val(mem_addr), "R6 tx data",
                  uart_tx_data, rd_val(mem_addr));
            uart_req[e] = 1'b0;
            @(negedge clk);
            chk(done_irq[e] == (k == 2), "R3 done timing",
                32'(done_irq[e]), 32'(k == 2));
          end
          @(negedge clk);
          chk(done_irq == 2'b00, "R3 done single pulse", 32'(done_irq), 32'd0);
        end

    // R5 R10 burst sweep with a grant stall
    for (int e = 0; e < 2; e++)
      for (int w = 0; w < 4; w++) begin
        step = (w == 0) ? 1 : (w == 1) ? 2 : 4;
        base = AW'(16'h2000 + e * 16'h100 + w * 16'h40);
        cfg(e, base, 4, w, 1'b0, 1'b1, 1'b0);
        uart_req[e] = 1'b1;
        @(negedge clk);
        uart_req[e] = 1'b0;
        for (int k = 0; k < 4; k++) begin
          if (k == 2) begin
            mem_gnt = 1'b0;
            #1;
            held = mem_addr;
            chk(mem_req && uart_ack == 2'b00, "R10 stall no ack",
                {30'd0, uart_ack}, 32'd0);
            @(negedge clk);
            chk(mem_req && mem_addr == held, "R10 held request",
                32'(mem_addr), 32'(held));
            mem_gnt = 1'b1;
          end
          if (e == 0) rx0 = 32'h7700_0000 + 32'(k);
          else        rx1 = 32'h8800_0000 + 32'(k);
          #1;
          chk(uart_ack[e], "R5 burst unit each cycle", 32'(uart_ack), 32'(1 << e));
          chk(mem_addr == base + AW'(k * step), "R2 burst address",
              32'(mem_addr), 32'(base + AW'(k * step)));
          chk(mem_size == ((w == 3) ? 2'd2 : 2'(w)), "R2 width code 3 is word",
              32'(mem_size), 32'((w == 3) ? 2 : w));
          chk(mem_wdata == (e == 0 ? rx0 : rx1), "R6 burst data",
              mem_wdata, (e == 0 ? rx0 : rx1));
          @(negedge clk);
        end
        chk(done_irq[e], "R3 burst done", 32'(done_irq), 32'(1 << e));
        chk(!mem_req, "R5 burst stops at count", 32'(mem_req), 32'd0);
        @(negedge clk);
      end

    // R7 paired memory-to-memory
    for (int w = 0; w < 3; w++) begin
      step = 1 << w;
      cfg(1, AW'(16'h9000 + w * 16'h100), 3, w, 1'b0, 1'b0, 1'b1);
      cfg(0, AW'(16'h8000 + w * 16'h100), 3, w, 1'b0, 1'b0, 1'b1);
      uart_req = 2'b11;
      seen = 0; d0 = 0; d1 = 0;
      for (int t = 0; t < 40; t++) begin
        if (mem_req && mem_gnt) begin
          if (seen % 2 == 0) begin
            base = AW'(16'h8000 + w * 16'h100 + (seen / 2) * step);
            chk(!mem_we && mem_addr == base, "R7 reader turn",
                32'(mem_addr), 32'(base));
          end else begin
            base = AW'(16'h9000 + w * 16'h100 + (seen / 2) * step);
            chk(mem_we && mem_addr == base, "R7 writer turn",
                32'(mem_addr), 32'(base));
            base = AW'(16'h8000 + w * 16'h100 + (seen / 2) * step);
            chk(mem_wdata == rd_val(base), "R7 data carried",
                mem_wdata, rd_val(base));
          end
          chk(uart_ack == 2'b00, "R7 no uart ack", 32'(uart_ack), 32'd0);
          seen++;
        end
        if (done_irq[0]) d0++;
        if (done_irq[1]) d1++;
        @(negedge clk);
      end
      uart_req = 2'b00;
      chk(seen == 6, "R7 unit total", 32'(seen), 32'd6);
      chk(d0 == 1 && d1 == 1, "R3 paired done", 32'(d0 + d1), 32'd2);
    end

    // R8 configuration while busy
    cfg(0, 16'h3000, 2, 2, 1'b0, 1'b0, 1'b0);
    cfg(0, 16'h4000, 5, 0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 2; k++) begin
      uart_req[0] = 1'b1;
      wait_ack(0, got);
      chk(got && mem_addr == AW'(16'h3000 + 4 * k) && mem_size == 2'd2,
          "R8 first setup kept", 32'(mem_addr), 32'(16'h3000 + 4 * k));
      uart_req[0] = 1'b0;
      @(negedge clk);
    end
    chk(done_irq[0], "R8 done after original count", 32'(done_irq), 32'd1);
    uart_req[0] = 1'b1;
    quiet(5, "R8 ignored write never runs");
    uart_req[0] = 1'b0;

    // R3 zero count
    cfg(1, 16'h3100, 0, 0, 1'b0, 1'b0, 1'b0);
    uart_req[1] = 1'b1;
    quiet(5, "R3 zero count idle");
    uart_req[1] = 1'b0;

    // R9 priority
    cfg(0, 16'h5000, 1, 2, 1'b0, 1'b0, 1'b0);
    cfg(1, 16'h6000, 1, 2, 1'b0, 1'b0, 1'b0);
    uart_req = 2'b11;
    @(negedge clk);
    chk(uart_ack == 2'b01, "R9 engine 0 first", 32'(uart_ack), 32'd1);
    uart_req[0] = 1'b0;
    @(negedge clk);
    chk(uart_ack == 2'b10, "R9 engine 1 next", 32'(uart_ack), 32'd2);
    uart_req[1] = 1'b0;
    @(negedge clk);

    // R9 started burst keeps the bus
    cfg(1, 16'h7000, 3, 2, 1'b0, 1'b1, 1'b0);
    cfg(0, 16'h7800, 1, 2, 1'b0, 1'b0, 1'b0);
    uart_req[1] = 1'b1;
    @(negedge clk);
    chk(uart_ack == 2'b10, "R9 burst unit 1", 32'(uart_ack), 32'd2);
    uart_req = 2'b01;
    @(negedge clk);
    chk(uart_ack == 2'b10, "R9 burst unit 2 kept", 32'(uart_ack), 32'd2);
    @(negedge clk);
    chk(uart_ack == 2'b10, "R9 burst unit 3 kept", 32'(uart_ack), 32'd2);
    @(negedge clk);
    chk(uart_ack == 2'b01, "R9 engine 0 after burst", 32'(uart_ack), 32'd1);
    uart_req = 2'b00;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule